// File: doc/BRIEF.md
# Indirect Register Access Port

This block lets a host that only reads and writes bytes reach a file of 16-bit registers that sits behind it. The host sees four byte-wide direct locations: the low half of a data word, the high half of that word, an index byte that names the target entry, and a status byte. The low and high halves sit at consecutive select codes.

The operation is chosen by the order of host writes. If a data byte has been written since the last access, a following index write starts a write of the data word into the named entry. If the index is written with no data write in between, the access is a read, and the fetched word lands in the two data bytes. The access does not happen at once. It waits in a busy state for a service tick, which models a once-per-sample slot in the slower domain. At that tick the access completes, busy drops, and a completion flag is raised. The flag drives an interrupt line through an enable bit and is cleared by writing 1 to it. Entry contents are undefined after reset.

Top module: `ind_reg_port`

## Requirements
- R1: After reset, the four direct locations read 0x00 (data low at select 0, data high at select 1, index at select 2, status at select 3), and `irq_o` is low.
- R2: Write one or both data bytes, then write the index. On the next service tick the 16-bit word {high, low} is stored in the entry named by the index.
- R3: An index write with no data write since the previous access is a read. On the service tick that completes it, the entry's word is loaded into data high and data low. Reads of direct locations do not count as data writes.
- R4: Status bit 0 (busy) reads 1 from the cycle after an accepted index write. It stays 1 through any number of cycles without a service tick and reads 0 after the clock edge at which a tick arrives while busy.
- R5: While busy, host writes to the index, data low and data high are ignored: the index and data bytes keep their values and the pending access targets the first index.
- R6: Completion sets status bit 1 (pending). Writing a status byte with bit 1 set clears pending, and writing it with bit 1 clear leaves pending unchanged. Status bit 2 is a read/write interrupt enable. `irq_o` is high exactly when pending and enable are both 1.
- R7: When a completion and a pending-clear write fall in the same cycle, pending ends up set.
- R8: An index at or above NUM_REGS (128 by default) names no entry. A write to it changes no entry, and a read from it returns 0x0000.
- R9: Writing only one data byte still marks the access as a write. The other byte keeps its current value and forms part of the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hst_sel | input | 2 | Direct location select: 0 data low, 1 data high, 2 index, 3 status |
| hst_we | input | 1 | Host write strobe for the selected location |
| hst_wdata | input | 8 | Host write byte |
| hst_rdata | output | 8 | Byte currently held at the selected location |
| svc_tick | input | 1 | Service slot strobe; a pending access completes here |
| irq_o | output | 1 | Completion interrupt, pending AND enable |

## Verification
A wrongly kept operation flag shows up at the first read-back after the next access. A write that is mistaken for a read leaves stale data bytes. A read that is mistaken for a write corrupts an entry, which a later read of that entry exposes. A busy flag that is stuck, or that drops early, is visible in the status byte in the very next cycle. A lost pending flag appears on `irq_o` as soon as enable is set. Writes ignored during busy, and indexes out of range, are checked by reading back the index byte and the returned data, so a leak through either shows up within one service tick.

// File: rtl/irp_pkg.sv
package irp_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  typedef enum logic [1:0] {
    SEL_DLO = 2'd0,
    SEL_DHI = 2'd1,
    SEL_IDX = 2'd2,
    SEL_STS = 2'd3
  } irp_sel_e;

  typedef enum logic {
    OP_READ  = 1'b0,
    OP_WRITE = 1'b1
  } irp_op_e;

  localparam int STS_BUSY = 0;
  localparam int STS_PEND = 1;
  localparam int STS_EN   = 2;
endpackage

// File: rtl/irp_rst_sync.sv
module irp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = sync_q[STAGES-1];
endmodule

// File: rtl/irp_engine.sv
module irp_engine
  import irp_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    idx_wr,
  input  logic    data_wr,
  input  logic    svc_tick,
  output logic    busy_o,
  output irp_op_e op_o,
  output logic    done_o
);
  logic    busy_q, busy_d;
  logic    dirty_q, dirty_d;
  irp_op_e op_q, op_d;

  assign done_o = busy_q & svc_tick;

  always_comb begin
    busy_d  = busy_q;
    dirty_d = dirty_q;
    op_d    = op_q;
    if (!busy_q) begin
      if (data_wr) dirty_d = 1'b1;
      if (idx_wr) begin
        busy_d  = 1'b1;
        op_d    = dirty_q ? OP_WRITE : OP_READ;
        dirty_d = 1'b0;
      end
    end else if (svc_tick) begin
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      dirty_q <= 1'b0;
      op_q    <= OP_READ;
    end else begin
      busy_q  <= busy_d;
      dirty_q <= dirty_d;
      op_q    <= op_d;
    end
  end

  assign busy_o = busy_q;
  assign op_o   = op_q;
endmodule

// File: rtl/irp_store.sv
module irp_store
  import irp_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NUM_REGS = 128
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] idx,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);
  localparam int FULL_SPAN = 1 << ADDR_W;
  localparam int SLOT_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [WORD_W-1:0] mem [NUM_REGS];
  logic              in_range;
  logic [SLOT_W-1:0] slot;

  generate
    if (NUM_REGS >= FULL_SPAN) begin : g_full
      assign in_range = 1'b1;
    end else begin : g_part
      assign in_range = ({1'b0, idx} < (ADDR_W+1)'(NUM_REGS));
    end
  endgenerate

  assign slot = SLOT_W'(idx);

  always_ff @(posedge clk) begin
    if (we && in_range) mem[slot] <= wdata;
  end

  assign rdata = in_range ? mem[slot] : '0;
endmodule

// File: rtl/irp_host_regs.sv
module irp_host_regs
  import irp_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        hst_sel,
  input  logic              hst_we,
  input  logic [BYTE_W-1:0] hst_wdata,
  output logic [BYTE_W-1:0] hst_rdata,
  input  logic              busy,
  input  logic              done,
  input  irp_op_e           op,
  input  logic [WORD_W-1:0] rd_word,
  output logic              idx_wr,
  output logic              data_wr,
  output logic [ADDR_W-1:0] idx_o,
  output logic [WORD_W-1:0] word_o,
  output logic              pend_o,
  output logic              en_o
);
  logic [BYTE_W-1:0] dlo_q, dlo_d, dhi_q, dhi_d;
  logic [ADDR_W-1:0] idx_q, idx_d;
  logic              pend_q, pend_d, en_q, en_d;
  logic              sts_wr;
  logic [BYTE_W-1:0] sts_byte;

  assign idx_wr  = hst_we && (hst_sel == SEL_IDX);
  assign data_wr = hst_we && ((hst_sel == SEL_DLO) || (hst_sel == SEL_DHI));
  assign sts_wr  = hst_we && (hst_sel == SEL_STS);

  always_comb begin
    dlo_d  = dlo_q;
    dhi_d  = dhi_q;
    idx_d  = idx_q;
    pend_d = pend_q;
    en_d   = en_q;
    if (!busy && hst_we) begin
      if (hst_sel == SEL_DLO) dlo_d = hst_wdata;
      if (hst_sel == SEL_DHI) dhi_d = hst_wdata;
      if (hst_sel == SEL_IDX) idx_d = hst_wdata[ADDR_W-1:0];
    end
    if (sts_wr) begin
      en_d = hst_wdata[STS_EN];
      if (hst_wdata[STS_PEND]) pend_d = 1'b0;
    end
    if (done) begin
      pend_d = 1'b1;
      if (op == OP_READ) {dhi_d, dlo_d} = rd_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dlo_q  <= '0;
      dhi_q  <= '0;
      idx_q  <= '0;
      pend_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      dlo_q  <= dlo_d;
      dhi_q  <= dhi_d;
      idx_q  <= idx_d;
      pend_q <= pend_d;
      en_q   <= en_d;
    end
  end

  always_comb begin
    sts_byte           = '0;
    sts_byte[STS_BUSY] = busy;
    sts_byte[STS_PEND] = pend_q;
    sts_byte[STS_EN]   = en_q;
    case (hst_sel)
      SEL_DLO: hst_rdata = dlo_q;
      SEL_DHI: hst_rdata = dhi_q;
      SEL_IDX: hst_rdata = BYTE_W'(idx_q);
      default: hst_rdata = sts_byte;
    endcase
  end

  assign idx_o  = idx_q;
  assign word_o = {dhi_q, dlo_q};
  assign pend_o = pend_q;
  assign en_o   = en_q;
endmodule

// File: rtl/ind_reg_port.sv
module ind_reg_port
  import irp_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NUM_REGS = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] hst_sel,
  input  logic       hst_we,
  input  logic [7:0] hst_wdata,
  output logic [7:0] hst_rdata,
  input  logic       svc_tick,
  output logic       irq_o
);
  logic              rst_n_s;
  logic              busy_w, done_w, idx_wr_w, data_wr_w, pend_w, en_w;
  irp_op_e           op_w;
  logic [ADDR_W-1:0] idx_w;
  logic [WORD_W-1:0] word_w, rd_word_w;

  irp_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s)
  );

  irp_engine u_eng (
    .clk(clk), .rst_n(rst_n_s), .idx_wr(idx_wr_w), .data_wr(data_wr_w),
    .svc_tick(svc_tick), .busy_o(busy_w), .op_o(op_w), .done_o(done_w)
  );

  irp_host_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .hst_sel(hst_sel), .hst_we(hst_we),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .busy(busy_w),
    .done(done_w), .op(op_w), .rd_word(rd_word_w), .idx_wr(idx_wr_w),
    .data_wr(data_wr_w), .idx_o(idx_w), .word_o(word_w), .pend_o(pend_w),
    .en_o(en_w)
  );

  irp_store #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_store (
    .clk(clk), .we(done_w && (op_w == OP_WRITE)), .idx(idx_w),
    .wdata(word_w), .rdata(rd_word_w)
  );

  assign irq_o = pend_w & en_w;
endmodule

// File: rtl/irp_checker.sv
module irp_checker #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        hst_sel,
  input logic              hst_we,
  input logic [7:0]        hst_wdata,
  input logic              svc_tick,
  input logic              busy,
  input logic              pend,
  input logic [ADDR_W-1:0] idx,
  input logic [15:0]       word
);
  // R4
  busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_we && hst_sel == 2'd2 && !busy) |=> busy);
  // R4
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !svc_tick) |=> busy);
  // R4
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && svc_tick) |=> !busy);
  // R6
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && svc_tick) |=> pend);
  // R6
  pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !(hst_we && hst_sel == 2'd3 && hst_wdata[1])) |=> pend);
  // R5
  idx_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(idx));
  // R5
  word_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !svc_tick) |=> $stable(word));
endmodule

bind ind_reg_port irp_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .hst_sel(hst_sel), .hst_we(hst_we),
  .hst_wdata(hst_wdata), .svc_tick(svc_tick), .busy(busy_w),
  .pend(pend_w), .idx(idx_w), .word(word_w)
);

// File: tb/test_ind_reg_port.sv
`timescale 1ns/1ps
module test_ind_reg_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] hst_sel = 2'd0;
  logic       hst_we = 1'b0;
  logic [7:0] hst_wdata = 8'd0;
  logic [7:0] hst_rdata;
  logic       svc_tick = 1'b0;
  logic       irq_o;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ind_reg_port i_ind_reg_port (
    .clk(clk), .rst_n(rst_n), .hst_sel(hst_sel), .hst_we(hst_we),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .svc_tick(svc_tick),
    .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hwr(input logic [1:0] sel, input logic [7:0] val);
    @(negedge clk);
    hst_sel = sel; hst_we = 1'b1; hst_wdata = val;
    @(negedge clk);
    hst_we = 1'b0;
  endtask

  task automatic hrd(input logic [1:0] sel, output logic [7:0] val);
    hst_sel = sel;
    #0.5;
    val = hst_rdata;
  endtask

  task automatic tick();
    @(negedge clk);
    svc_tick = 1'b1;
    @(negedge clk);
    svc_tick = 1'b0;
  endtask

  task automatic chk_reg(input string req, input logic [1:0] sel, input logic [7:0] exp);
    logic [7:0] v;
    hrd(sel, v);
    check(req, {8'h00, v}, {8'h00, exp});
  endtask

  task automatic chk_word(input string req, input logic [15:0] exp);
    logic [7:0] lo, hi;
    hrd(2'd0, lo);
    hrd(2'd1, hi);
    check(req, {hi, lo}, exp);
  endtask

  task automatic t_reset();
    chk_reg("R1 data low", 2'd0, 8'h00);
    chk_reg("R1 data high", 2'd1, 8'h00);
    chk_reg("R1 index", 2'd2, 8'h00);
    chk_reg("R1 status", 2'd3, 8'h00);
    check("R1 irq", {15'd0, irq_o}, 16'd0);
  endtask

  task automatic t_write_read();
    hwr(2'd0, 8'h34); hwr(2'd1, 8'h12); hwr(2'd2, 8'd5);
    chk_reg("R4 busy after index write", 2'd3, 8'h01);
    tick();
    chk_reg("R2 done status", 2'd3, 8'h02);
    hwr(2'd3, 8'h02);
    chk_reg("R6 pending cleared", 2'd3, 8'h00);
    hwr(2'd0, 8'hEF); hwr(2'd1, 8'hBE); hwr(2'd2, 8'd6); tick();
    hwr(2'd2, 8'd5);
    chk_word("R3 data before tick", 16'hBEEF);
    tick();
    chk_word("R3 read returns entry 5", 16'h1234);
  endtask

  task automatic t_busy_hold();
    hwr(2'd2, 8'd6);
    repeat (3) @(negedge clk);
    chk_reg("R4 busy holds without tick", 2'd3, 8'h03);
    chk_word("R4 no access before tick", 16'h1234);
    tick();
    chk_reg("R4 busy cleared by tick", 2'd3, 8'h02);
    chk_word("R2 entry 6 stored", 16'hBEEF);
  endtask

  task automatic t_ignore_busy();
    hwr(2'd2, 8'd5);
    hwr(2'd2, 8'd6);
    hwr(2'd0, 8'h77);
    chk_reg("R5 index kept", 2'd2, 8'd5);
    chk_reg("R5 data low kept", 2'd0, 8'hEF);
    tick();
    chk_word("R5 first index served", 16'h1234);
  endtask

  task automatic t_irq();
    hwr(2'd3, 8'h02);
    hwr(2'd2, 8'd6); tick();
    check("R6 irq masked", {15'd0, irq_o}, 16'd0);
    hwr(2'd3, 8'h04);
    chk_reg("R6 enable set, pending kept", 2'd3, 8'h06);
    check("R6 irq raised", {15'd0, irq_o}, 16'd1);
    hwr(2'd3, 8'h06);
    chk_reg("R6 clear by writing 1", 2'd3, 8'h04);
    check("R6 irq dropped", {15'd0, irq_o}, 16'd0);
  endtask

  task automatic t_collide();
    hwr(2'd2, 8'd5);
    @(negedge clk);
    hst_sel = 2'd3; hst_we = 1'b1; hst_wdata = 8'h06; svc_tick = 1'b1;
    @(negedge clk);
    hst_we = 1'b0; svc_tick = 1'b0;
    chk_reg("R7 set wins over clear", 2'd3, 8'h06);
    check("R7 irq", {15'd0, irq_o}, 16'd1);
    hwr(2'd3, 8'h02);
  endtask

  task automatic t_range();
    hwr(2'd0, 8'hAA); hwr(2'd1, 8'hAA); hwr(2'd2, 8'd133); tick();
    hwr(2'd2, 8'd5); tick();
    chk_word("R8 no alias into entry 5", 16'h1234);
    hwr(2'd2, 8'd133); tick();
    chk_word("R8 out-of-range read is zero", 16'h0000);
  endtask

  task automatic t_partial();
    hwr(2'd1, 8'h56); hwr(2'd2, 8'd7); tick();
    hwr(2'd2, 8'd5); tick();
    chk_word("R9 intervening read", 16'h1234);
    hwr(2'd2, 8'd7); tick();
    chk_word("R9 single byte write stored", 16'h5600);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_write_read();
    t_busy_hold();
    t_ignore_busy();
    t_irq();
    t_collide();
    t_range();
    t_partial();
    finish_run();
  end
endmodule